// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the address that a synchronous SRAM array uses in each cycle. A full external address is captured whenever either of two load strobes is high. After a load, an advance input walks the two lowest address bits through a four-beat burst. The upper bits stay at the value captured on the load.

An order-select input chooses between two burst orders. In linear order the low bits count upward and wrap. In interleaved order the low bits are the loaded low bits XORed with the beat number. The select is high for interleaved order, which is also the state a pulled-up, undriven select pin would give.

Bursting is optional. A controller may load a fresh address on every cycle with no idle cycle in between. The output is registered and shows the result of a clock edge one cycle after the inputs were sampled.

Top module: `burst_seq`

## Requirements
- R1: While reset is low, and in the first cycle after it, burstAddr is all zeros.
- R2: When loadStrobeHost is high at a clock edge, burstAddr equals addrIn from that edge right after the edge.
- R3: When loadStrobeCtrl is high at a clock edge, burstAddr equals addrIn from that edge right after the edge.
- R4: With interleaveSel low (linear order), each edge with advance high and no strobe sets the two low bits of burstAddr to the loaded low bits plus the beat count, modulo 4. From a loaded low value of 1 this gives 2, 3, 0, 1.
- R5: With interleaveSel high (interleaved order), each edge with advance high and no strobe sets the two low bits to the loaded low bits XOR the beat count. The beat count steps 1, 2, 3, 0, so a loaded low value of 1 gives 0, 3, 2, 1.
- R6: Bits above the two low bits of burstAddr do not change on an advance.
- R7: An edge with no strobe and advance low leaves burstAddr unchanged.
- R8: When a strobe and advance are high at the same edge, the strobe wins. burstAddr takes addrIn and the beat count restarts at 0.
- R9: Loads on consecutive edges, from either strobe, each appear on burstAddr in the cycle after their edge, with no gap between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous reset, active low |
| addrIn | input | ADDR_W | External address, captured on a load |
| loadStrobeHost | input | 1 | First load strobe, active high |
| loadStrobeCtrl | input | 1 | Second load strobe, active high |
| advance | input | 1 | Step the burst by one beat, active high |
| interleaveSel | input | 1 | 1 selects interleaved order, 0 selects linear order |
| burstAddr | output | ADDR_W | Current full address sent to the array |

## Verification
Two functions can fall in the same cycle: loading a new address and advancing the current burst. The bench provokes this by raising a strobe together with advance in the middle of a burst, in both orders. It then judges the edge by whether burstAddr takes the new address, rather than the next beat of the old burst. It also checks that the advances that follow restart from beat 0 of the new address. Loads on consecutive edges, alternating between the two strobes, are checked against the scoreboard cycle by cycle.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  // Per-cycle commands from the control module to the datapath.
  typedef struct packed {
    logic load;  // capture the external address
    logic step;  // move to the next beat of the burst
  } seqCtl_t;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } burstOrder_t;

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic    loadStrobeHost,
  input  logic    loadStrobeCtrl,
  input  logic    advance,
  output seqCtl_t ctl
);

  logic anyStrobe;

  // Either strobe starts a new burst, and a load always takes
  // priority over stepping the current burst.
  always_comb begin
    anyStrobe = loadStrobeHost | loadStrobeCtrl;
    ctl.load  = anyStrobe;
    ctl.step  = advance & ~anyStrobe;
  end

endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              interleaveSel,
  input  seqCtl_t           ctl,
  output logic [ADDR_W-1:0] curAddr
);

  localparam int UPPER_W = ADDR_W - CNT_W;

  burstOrder_t       order;
  logic [CNT_W-1:0]  baseLow;
  logic [CNT_W-1:0]  beatCnt;
  logic [CNT_W-1:0]  nextBeat;
  logic [CNT_W-1:0]  linLow;
  logic [CNT_W-1:0]  ilvLow;
  logic [CNT_W-1:0]  nextLow;

  assign order    = burstOrder_t'(interleaveSel);
  assign nextBeat = beatCnt + 1'b1;
  assign linLow   = baseLow + nextBeat;

  // The interleaved order needs one XOR gate per counter bit.
  for (genvar g = 0; g < CNT_W; g++) begin : g_ilv
    assign ilvLow[g] = baseLow[g] ^ nextBeat[g];
  end

  assign nextLow = (order == ORDER_INTERLEAVE) ? ilvLow : linLow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseLow <= '0;
      beatCnt <= '0;
      curAddr <= '0;
    end else if (ctl.load) begin
      baseLow <= addrIn[CNT_W-1:0];
      beatCnt <= '0;
      curAddr <= addrIn;
    end else if (ctl.step) begin
      beatCnt              <= nextBeat;
      curAddr[CNT_W-1:0]   <= nextLow;
    end
  end

  // R2/R3: a load presents the captured address in the next cycle.
  p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> curAddr == $past(addrIn));

  // R7: with no command, the address stays where it is.
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && !ctl.step) |=> $stable(curAddr));

  // R6: a step never touches the upper address bits.
  p_upper_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> curAddr[ADDR_W-1:CNT_W] == $past(curAddr[ADDR_W-1:CNT_W]));

  // R4: in linear order, each step adds one to the low bits.
  p_linear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && !interleaveSel) |=>
      curAddr[CNT_W-1:0] == CNT_W'($past(curAddr[CNT_W-1:0]) + 1'b1));

  // R5: in interleaved order, bit 0 toggles on every step.
  p_interleave_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && interleaveSel) |=>
      curAddr[0] != $past(curAddr[0]));

  logic [UPPER_W-1:0] unusedUpper;
  assign unusedUpper = '0;

endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              loadStrobeHost,
  input  logic              loadStrobeCtrl,
  input  logic              advance,
  input  logic              interleaveSel,
  output logic [ADDR_W-1:0] burstAddr
);

  seqCtl_t ctl;

  burst_seq_ctrl i_ctrl (
    .loadStrobeHost (loadStrobeHost),
    .loadStrobeCtrl (loadStrobeCtrl),
    .advance        (advance),
    .ctl            (ctl)
  );

  burst_seq_dp #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) i_dp (
    .clk           (clk),
    .rstN          (rstN),
    .addrIn        (addrIn),
    .interleaveSel (interleaveSel),
    .ctl           (ctl),
    .curAddr       (burstAddr)
  );

  // R8: a strobe together with advance still loads the new address.
  p_strobe_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((loadStrobeHost || loadStrobeCtrl) && advance) |=> burstAddr == $past(addrIn));

  // R3: the second strobe loads on its own as well.
  p_ctrl_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobeCtrl |=> burstAddr == $past(addrIn));

endmodule

// File: tb/test_burst_seq.sv
`timescale 1ns/1ps
module test_burst_seq;

  localparam int ADDR_W = 20;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic              loadStrobeHost = 1'b0;
  logic              loadStrobeCtrl = 1'b0;
  logic              advance = 1'b0;
  logic              interleaveSel = 1'b0;
  logic [ADDR_W-1:0] burstAddr;

  always #2.5 clk = ~clk;

  burst_seq i_burst_seq (
    .clk            (clk),
    .rstN           (rstN),
    .addrIn         (addrIn),
    .loadStrobeHost (loadStrobeHost),
    .loadStrobeCtrl (loadStrobeCtrl),
    .advance        (advance),
    .interleaveSel  (interleaveSel),
    .burstAddr      (burstAddr)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [ADDR_W-1:0] expQ[$];
  string             tagQ[$];

  // Reference model state.
  logic [ADDR_W-1:0] mBase = '0;
  logic [1:0]        mBeat = '0;
  logic [ADDR_W-1:0] mAddr = '0;

  task automatic step(input bit sa, input bit sb, input bit adv, input bit ilv,
                      input logic [ADDR_W-1:0] a, input string tag);
    logic [1:0] low;
    @(negedge clk);
    loadStrobeHost = sa;
    loadStrobeCtrl = sb;
    advance        = adv;
    interleaveSel  = ilv;
    addrIn         = a;
    if (sa || sb) begin
      mBase = a;
      mBeat = 2'd0;
      mAddr = a;
    end else if (adv) begin
      mBeat = mBeat + 2'd1;
      low   = ilv ? (mBase[1:0] ^ mBeat) : (mBase[1:0] + mBeat);
      mAddr = {mBase[ADDR_W-1:2], low};
    end
    expQ.push_back(mAddr);
    tagQ.push_back(tag);
  endtask

  // Monitor: compare one expected item after each edge.
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      logic [ADDR_W-1:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (burstAddr !== e) begin
        fails++;
        $display("FAIL %s: burstAddr=%h expected=%h", t, burstAddr, e);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset value
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (burstAddr !== '0) begin
      fails++;
      $display("FAIL R1: burstAddr=%h expected=0", burstAddr);
    end
    @(negedge clk);
    rstN = 1'b1;
    step(0, 0, 0, 0, 20'h0, "R1 first cycle after reset");

    // R2 then R4 linear with wrap, R6 upper stable
    step(1, 0, 0, 0, 20'h12341, "R2 host load");
    for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 20'hFFFFF, "R4 R6 linear step");

    // R3 then R5 interleaved with wrap
    step(0, 1, 0, 1, 20'hABCD1, "R3 ctrl load");
    for (int i = 0; i < 5; i++) step(0, 0, 1, 1, 20'h00000, "R5 R6 interleaved step");

    // R7: holds mixed with advances
    step(1, 0, 0, 1, 20'h55552, "R2 host load");
    step(0, 0, 0, 1, 20'h00003, "R7 hold");
    step(0, 0, 1, 1, 20'h00003, "R5 step");
    step(0, 0, 0, 0, 20'hFFFFF, "R7 hold");
    step(0, 0, 0, 1, 20'h12345, "R7 hold");
    step(0, 0, 1, 0, 20'h00000, "R4 step");

    // R8: strobe and advance together, mid-burst, both orders
    step(1, 0, 1, 0, 20'h7A5B3, "R8 host load with advance");
    step(0, 0, 1, 0, 20'h0, "R8 R4 beat restart");
    step(0, 0, 1, 0, 20'h0, "R8 R4 beat restart");
    step(0, 1, 1, 1, 20'hC0DE2, "R8 ctrl load with advance");
    step(0, 0, 1, 1, 20'h0, "R8 R5 beat restart");
    step(1, 1, 1, 1, 20'h3C3C1, "R8 both strobes with advance");
    step(0, 0, 1, 1, 20'h0, "R8 R5 beat restart");

    // R9: back-to-back loads alternating strobes
    for (int i = 0; i < 8; i++)
      step(i[0] == 1'b0, i[0] == 1'b1, i[1], i[2], 20'h10000 + 20'(i * 4097), "R9 back-to-back load");
    step(0, 0, 1, 0, 20'h0, "R9 R4 step after loads");

    @(negedge clk);
    loadStrobeHost = 1'b0;
    loadStrobeCtrl = 1'b0;
    advance        = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule